// File: doc/BRIEF.md
# SDRAM Burst Read Sequencer

This block turns a read command on the SDRAM command pins into the column address sequence for one burst from an already open row. It also produces the timing of the data beats on the bus. Each beat's column is produced one cycle after the edge that generates it. The same beat reaches the data side through a short shift pipeline, so the first data beat appears exactly CAS-latency cycles after the read edge. A flag marks the final beat of a burst that runs to completion.

Burst length, address ordering and CAS latency come from mode inputs. A burst can be cut short in four ways:
- A new read takes over at once. Its data follows the beats already in flight with no idle cycle.
- A burst stop ends column generation but lets the in-flight beats drain.
- A precharge to the burst's own bank ends column generation in the same way.
- A write clears everything at once, because the bus is about to carry write data.

Top module: `sdram_rd_burst_seq`

## Requirements
- R1: A read is decoded only when cs_n=0, ras_n=1, cas_n=0 and we_n=1 at a rising edge. A deselected bus (cs_n=1), an activate (0,0,1,1), an idle precharge (0,0,1,0) and an idle burst stop (0,1,1,0) start nothing. After reset, col_vld, dq_oe and burst_end are low.
- R2: In the cycle after a read edge, col_vld is high and col_out equals the col_in sampled with the read.
- R3: Sequential order (ilv=0): beat k carries the start column's upper bits unchanged. Its low log2(BL) bits are (start + k) mod BL. Exactly BL beats are produced.
- R4: Interleaved order (ilv=1): beat k's low log2(BL) bits are start XOR k, and the upper bits are kept.
- R5: dq_oe is high from CL cycles after the read edge for BL consecutive cycles, with dq_col giving each beat's column. cl3=0 selects CL=2 and cl3=1 selects CL=3.
- R6: bl_sel codes 0, 1, 2 and 3 give BL 1, 2, 4 and 8. Code 7 gives full page, and codes 4 to 6 act as BL 1. burst_end is high during the final data beat of a completed burst. A full-page burst never raises burst_end, wraps around the whole row, and always uses sequential order.
- R7: A read issued during a burst restarts column generation at the new column on the next cycle. The previous burst's issued beats still appear on the data side, followed by the new ones with no gap. The truncated burst raises no burst_end.
- R8: A burst stop (cs_n=0, ras_n=1, cas_n=1, we_n=0) halts column generation from the next cycle. Beats already issued still appear on the data side, and then dq_oe falls.
- R9: A precharge (cs_n=0, ras_n=0, cas_n=1, we_n=0) whose ba equals the bank latched with the read ends the burst like a burst stop. A precharge to another bank has no effect.
- R10: A write (cs_n=0, ras_n=1, cas_n=0, we_n=0) drops col_vld and dq_oe from the next cycle, discarding every beat still in the latency pipeline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W | Bank address |
| col_in | input | COL_W | Start column of a read |
| bl_sel | input | 3 | Burst length code |
| ilv | input | 1 | 1 = interleaved order, 0 = sequential |
| cl3 | input | 1 | 1 = CAS latency 3, 0 = CAS latency 2 |
| col_out | output | COL_W | Column of the beat being generated |
| col_vld | output | 1 | col_out is a live beat |
| dq_oe | output | 1 | Data beat on the bus, drive enable |
| dq_col | output | COL_W | Column of the beat now on the bus |
| burst_end | output | 1 | Final beat of a completed burst |

## Verification
The bench targets the wrap boundary in both orderings and the full-page wrap from the last column to column zero. An adder that carries into the upper bits would leave the aligned block, and an interleave applied to full page would scramble the row.

It chains a read onto a partly issued burst and checks that data stays continuous. A sequencer that flushed the pipeline on a new read would open a gap, and one that flagged the old burst's end would raise burst_end early.

Stop and precharge are checked to let the in-flight beats drain, while a write is checked to kill them. Swapping these two behaviours either clips valid data or drives the bus into write data. Precharge to another bank and non-read command patterns are checked to leave the outputs quiet or untouched.

// File: rtl/sdram_rd_burst_seq.sv
module sdram_rd_burst_seq #(
  parameter int COL_W = 9,
  parameter int BA_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             ras_n,
  input  logic             cas_n,
  input  logic             we_n,
  input  logic [BA_W-1:0]  ba,
  input  logic [COL_W-1:0] col_in,
  input  logic [2:0]       bl_sel,
  input  logic             ilv,
  input  logic             cl3,
  output logic [COL_W-1:0] col_out,
  output logic             col_vld,
  output logic             dq_oe,
  output logic [COL_W-1:0] dq_col,
  output logic             burst_end
);
  localparam int PIPE = 3;

  function automatic logic [COL_W-1:0] len_mask(input logic [2:0] s);
    case (s)
      3'd1:    return COL_W'(1);
      3'd2:    return COL_W'(3);
      3'd3:    return COL_W'(7);
      3'd7:    return '1;
      default: return '0;
    endcase
  endfunction

  function automatic logic [COL_W-1:0] beat_col(input logic [COL_W-1:0] s,
      input logic [COL_W-1:0] k, input logic [COL_W-1:0] m, input logic x);
    logic [COL_W-1:0] low;
    low = x ? (s ^ k) : (s + k);
    return (s & ~m) | (low & m);
  endfunction

  wire sel = !cs_n;
  wire rd  = sel &  ras_n & !cas_n &  we_n;
  wire wr  = sel &  ras_n & !cas_n & !we_n;
  wire bst = sel &  ras_n &  cas_n & !we_n;
  wire pre = sel & !ras_n &  cas_n & !we_n;

  logic [COL_W-1:0] start_q, cnt_q, mask_q;
  logic [BA_W-1:0]  bank_q;
  logic             ilv_q, fp_q, col_last;

  wire              kill    = wr | bst | (pre & (ba == bank_q));
  wire [COL_W-1:0]  m_new   = len_mask(bl_sel);
  wire              fp_new  = (bl_sel == 3'd7);
  wire [COL_W-1:0]  cnt_nx  = cnt_q + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= '0; cnt_q <= '0; mask_q <= '0; bank_q <= '0;
      ilv_q <= 1'b0; fp_q <= 1'b0;
      col_out <= '0; col_vld <= 1'b0; col_last <= 1'b0;
    end else if (rd) begin
      start_q  <= col_in;
      cnt_q    <= '0;
      mask_q   <= m_new;
      bank_q   <= ba;
      ilv_q    <= ilv & !fp_new;
      fp_q     <= fp_new;
      col_out  <= col_in;
      col_vld  <= 1'b1;
      col_last <= !fp_new && (m_new == '0);
    end else if (kill) begin
      col_vld  <= 1'b0;
      col_last <= 1'b0;
    end else if (col_vld) begin
      if (col_last) begin
        col_vld  <= 1'b0;
        col_last <= 1'b0;
      end else begin
        cnt_q    <= cnt_nx;
        col_out  <= beat_col(start_q, cnt_nx, mask_q, ilv_q);
        col_last <= !fp_q && (cnt_nx == mask_q);
      end
    end
  end

  logic [PIPE-1:0]  vp, lp;
  logic [COL_W-1:0] cp [PIPE];

  always_ff @(posedge clk) begin
    if (!rst_n || wr) begin
      vp <= '0;
      lp <= '0;
      for (int i = 0; i < PIPE; i++) cp[i] <= '0;
    end else begin
      vp    <= {vp[PIPE-2:0], col_vld};
      lp    <= {lp[PIPE-2:0], col_last};
      cp[0] <= col_out;
      for (int i = 1; i < PIPE; i++) cp[i] <= cp[i-1];
    end
  end

  assign dq_oe     = cl3 ? vp[2] : vp[1];
  assign dq_col    = cl3 ? cp[2] : cp[1];
  assign burst_end = cl3 ? lp[2] : lp[1];

  a_r2_first_beat: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> (col_vld && col_out == $past(col_in)));
  a_r3_stay_in_block: assert property (@(posedge clk) disable iff (!rst_n)
    (col_vld && !col_last && !rd && !kill) |=> (((col_out ^ $past(col_out)) & ~mask_q) == '0));
  a_r6_end_on_beat: assert property (@(posedge clk) disable iff (!rst_n)
    burst_end |-> dq_oe);
  a_r6_page_no_end: assert property (@(posedge clk) disable iff (!rst_n)
    (col_vld && fp_q) |-> !col_last);
  a_r8_stop_halts: assert property (@(posedge clk) disable iff (!rst_n)
    bst |=> !col_vld);
  a_r9_other_bank: assert property (@(posedge clk) disable iff (!rst_n)
    (pre && ba != bank_q && col_vld && !col_last) |=> col_vld);
  a_r10_write_flush: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (!col_vld && !dq_oe && !burst_end));
endmodule

// File: tb/sdram_rd_burst_seq_tb.sv
module sdram_rd_burst_seq_tb;
  localparam logic [3:0] RD = 4'b0101, WR = 4'b0100, PRE = 4'b0010,
                         BST = 4'b0110, NOP = 4'b0111, DES = 4'b1101, ACT = 4'b0011;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n, ras_n, cas_n, we_n, ilv = 1'b0, cl3 = 1'b0;
  logic [1:0] ba = '0;
  logic [8:0] col_in = '0;
  logic [2:0] bl_sel = '0;
  logic [8:0] col_out, dq_col;
  logic col_vld, dq_oe, burst_end;
  int errors = 0, checks = 0;

  logic [3:0] q_cmd [32];
  logic [1:0] q_ba  [32];
  logic [8:0] q_col [32];
  logic       o_oe [32], o_end [32], o_cv [32];
  logic [8:0] o_col [32], o_cout [32];

  always #10 clk = ~clk;

  sdram_rd_burst_seq u_dut (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .col_in(col_in), .bl_sel(bl_sel), .ilv(ilv),
    .cl3(cl3), .col_out(col_out), .col_vld(col_vld), .dq_oe(dq_oe), .dq_col(dq_col),
    .burst_end(burst_end));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clr();
    for (int i = 0; i < 32; i++) begin q_cmd[i] = NOP; q_ba[i] = '0; q_col[i] = '0; end
  endtask

  task automatic put(input int i, input logic [3:0] c, input logic [1:0] b, input logic [8:0] col);
    q_cmd[i] = c; q_ba[i] = b; q_col[i] = col;
  endtask

  task automatic play(input int n);
    for (int i = 0; i < n; i++) begin
      {cs_n, ras_n, cas_n, we_n} = q_cmd[i];
      ba = q_ba[i]; col_in = q_col[i];
      @(negedge clk);
      o_oe[i] = dq_oe; o_end[i] = burst_end; o_col[i] = dq_col;
      o_cv[i] = col_vld; o_cout[i] = col_out;
    end
    {cs_n, ras_n, cas_n, we_n} = NOP;
  endtask

  function automatic int ecol(input int s, input int k, input int len, input bit x);
    int hi, lo;
    hi = s - (s % len);
    lo = x ? ((s % len) ^ k) : ((s + k) % len);
    return hi + lo;
  endfunction

  task automatic t_burst(input string tag, input logic [2:0] code, input int len,
                         input bit x, input bit c3, input int s);
    int cl;
    cl = c3 ? 3 : 2;
    bl_sel = code; ilv = x; cl3 = c3;
    clr(); put(0, RD, 2'd0, 9'(s));
    play(cl + len + 3);
    chk({tag, " R2 col_out"}, o_cout[0], s);
    chk({tag, " R2 col_vld"}, o_cv[0], 1);
    for (int i = 0; i < cl + len + 3; i++) begin
      chk({tag, " R5 dq_oe"}, o_oe[i], (i >= cl && i < cl + len));
      if (i >= cl && i < cl + len)
        chk({tag, x ? " R4 column" : " R3 column"}, o_col[i], ecol(s, i - cl, len, x));
      chk({tag, " R6 burst_end"}, o_end[i], (i == cl + len - 1));
    end
  endtask

  task automatic t_decode();
    cl3 = 1'b0; bl_sel = 3'd2;
    clr(); put(0, DES, 2'd0, 9'd5); put(1, ACT, 2'd0, 9'd5);
    put(2, PRE, 2'd0, 9'd5); put(3, BST, 2'd0, 9'd5);
    play(9);
    for (int i = 0; i < 9; i++) begin
      chk("R1 no col_vld", o_cv[i], 0);
      chk("R1 no dq_oe", o_oe[i], 0);
    end
  endtask

  task automatic t_fullpage();
    int exp;
    bl_sel = 3'd7; ilv = 1'b1; cl3 = 1'b0;
    clr(); put(0, RD, 2'd0, 9'd509); put(6, BST, 2'd0, 9'd0);
    play(12);
    chk("R8 col_vld before stop", o_cv[5], 1);
    chk("R8 col_vld after stop", o_cv[6], 0);
    for (int i = 0; i < 12; i++) begin
      chk("R8 dq_oe drain", o_oe[i], (i >= 2 && i < 8));
      chk("R6 full page no end", o_end[i], 0);
      if (i >= 2 && i < 8) begin
        exp = (509 + i - 2) % 512;
        chk("R6 full page wrap", o_col[i], exp);
      end
    end
  endtask

  task automatic t_chain_mid();
    int exp_c [6] = '{4, 5, 9, 10, 11, 8};
    bl_sel = 3'd2; ilv = 1'b0; cl3 = 1'b1;
    clr(); put(0, RD, 2'd0, 9'd4); put(2, RD, 2'd1, 9'd9);
    play(12);
    for (int i = 0; i < 12; i++) begin
      chk("R7 chained dq_oe", o_oe[i], (i >= 3 && i < 9));
      if (i >= 3 && i < 9) chk("R7 chained column", o_col[i], exp_c[i-3]);
      chk("R7 only new burst ends", o_end[i], (i == 8));
    end
  endtask

  task automatic t_chain_full();
    int exp_c [8] = '{4, 5, 6, 7, 20, 21, 22, 23};
    bl_sel = 3'd2; ilv = 1'b0; cl3 = 1'b0;
    clr(); put(0, RD, 2'd0, 9'd4); put(4, RD, 2'd0, 9'd20);
    play(12);
    for (int i = 0; i < 12; i++) begin
      chk("R7 gapless dq_oe", o_oe[i], (i >= 2 && i < 10));
      if (i >= 2 && i < 10) chk("R7 gapless column", o_col[i], exp_c[i-2]);
      chk("R7 both ends", o_end[i], (i == 5 || i == 9));
    end
  endtask

  task automatic t_precharge();
    bl_sel = 3'd3; ilv = 1'b0; cl3 = 1'b0;
    clr(); put(0, RD, 2'd1, 9'd3); put(1, PRE, 2'd2, 9'd0);
    play(13);
    for (int i = 0; i < 13; i++) begin
      chk("R9 other bank dq_oe", o_oe[i], (i >= 2 && i < 10));
      if (i >= 2 && i < 10) chk("R9 other bank column", o_col[i], ecol(3, i - 2, 8, 1'b0));
      chk("R9 other bank end", o_end[i], (i == 9));
    end
    clr(); put(0, RD, 2'd1, 9'd3); put(3, PRE, 2'd1, 9'd0);
    play(10);
    for (int i = 0; i < 10; i++) begin
      chk("R9 same bank dq_oe", o_oe[i], (i >= 2 && i < 5));
      chk("R9 same bank no end", o_end[i], 0);
    end
    chk("R9 same bank last column", o_col[4], 5);
  endtask

  task automatic t_write();
    bl_sel = 3'd3; ilv = 1'b0; cl3 = 1'b1;
    clr(); put(0, RD, 2'd0, 9'd0); put(2, WR, 2'd0, 9'd0);
    play(12);
    chk("R10 col_vld before write", o_cv[1], 1);
    for (int i = 2; i < 12; i++) begin
      chk("R10 col_vld cleared", o_cv[i], 0);
      chk("R10 dq_oe flushed", o_oe[i], 0);
      chk("R10 no end", o_end[i], 0);
    end
  endtask

  initial begin
    #(20 * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    {cs_n, ras_n, cas_n, we_n} = NOP;
    repeat (3) @(negedge clk);
    chk("R1 reset col_vld", col_vld, 0);
    chk("R1 reset dq_oe", dq_oe, 0);
    chk("R1 reset burst_end", burst_end, 0);
    rst_n = 1'b1;
    @(negedge clk);
    t_decode();
    t_burst("BL4 seq CL2", 3'd2, 4, 1'b0, 1'b0, 6);
    t_burst("BL8 seq CL3", 3'd3, 8, 1'b0, 1'b1, 13);
    t_burst("BL2 seq CL2", 3'd1, 2, 1'b0, 1'b0, 3);
    t_burst("BL1 CL3", 3'd0, 1, 1'b0, 1'b1, 13);
    t_burst("BL8 ilv CL2", 3'd3, 8, 1'b1, 1'b0, 5);
    t_burst("BL4 ilv CL3", 3'd2, 4, 1'b1, 1'b1, 70);
    t_fullpage();
    t_chain_mid();
    t_chain_full();
    t_precharge();
    t_write();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule